// File: doc/BRIEF.md
# Write-Protect Unlock Sequencer

This block stands in front of a small register file and a byte-wide standby RAM. It decides, for every bus write, whether that write may land. Out of reset the space is locked. The only thing software can do while it is locked is write the 2-bit write-enable field, which sits in bits [1:0] of the control register. Once that field has been given the right four values in a row, a write window opens. The window is measured in ticks of a slow time base, typically 1 Hz. When the window runs out, the lock closes again by itself.

While the window is open, every write is qualified. A write whose address falls inside the standby RAM range also raises a RAM strobe and a zero-based byte index. A status output reports whether protection is in force. Software can close the window early by writing the final code of the sequence on its own. It can extend the window by repeating the full sequence.

Top module: `wp_knock_guard`

## Requirements
- R1: After reset, `wp_active` is 1 and every write to an address other than `CTRL_ADDR` has `wr_ok` = 0.
- R2: A write to `CTRL_ADDR` always has `wr_ok` = 1, whether protection is active or not.
- R3: Four control writes in a row whose field (`wr_data[1:0]`) is 00, then 01, then 11, then 10 clear `wp_active` from the cycle after the fourth write. Non-control writes placed between the steps do not disturb the sequence.
- R4: A control write whose field is not the next expected step sends the detector back to idle. If that breaking write carries 00, it counts as the first step of a new sequence.
- R5: While `wp_active` is 0, every write gets `wr_ok` = 1.
- R6: On unlock, the window is loaded with `WIN_TICKS` ticks. Each `tick` pulse consumes one. The cycle after the tick that uses up the last one, `wp_active` returns to 1. Ticks arriving while locked have no effect.
- R7: A control write with field 10 that does not complete a sequence sets `wp_active` to 1 from the next cycle.
- R8: Control writes with field 00, 01 or 11 never change `wp_active`.
- R9: Completing the sequence while the window is already open reloads the window to the full `WIN_TICKS`.
- R10: `ram_wr` is 1 exactly when a write is qualified and its address lies in [`RAM_BASE`, `RAM_BASE`+`RAM_BYTES`). In that case `ram_idx` equals the address minus `RAM_BASE`. A RAM write made while locked gives `ram_wr` = 0.
- R11: If the unlock write and a `tick` arrive in the same cycle, the unlock wins and the full window is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; bits [1:0] are the write-enable field for control writes |
| tick | input | 1 | One-cycle pulse from the slow time base |
| wr_ok | output | 1 | The current write may be performed |
| ram_wr | output | 1 | A qualified write targets the standby RAM |
| ram_idx | output | $clog2(RAM_BYTES) | Byte index within the standby RAM |
| wp_active | output | 1 | 1 while protection is in force |

## Verification
The bench builds the block with an 8-bit address, a 64-byte RAM at 0x40 and a three-tick window. With these values both RAM edges (0x7F inside, 0x80 outside) can be reached with short addresses. Full window expiry, restart and tick/unlock collisions also happen within a few dozen cycles. Each cycle, a behavioural model tracks the sequence position and the remaining ticks. The qualifier, RAM strobe, index and status are compared against that model.

// File: rtl/wp_knock_guard.sv
module wp_knock_guard #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int CTRL_ADDR = 'h10,
  parameter int RAM_BASE  = 'h40,
  parameter int RAM_BYTES = 2048,
  parameter int WIN_TICKS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         tick,
  output logic                         wr_ok,
  output logic                         ram_wr,
  output logic [$clog2(RAM_BYTES)-1:0] ram_idx,
  output logic                         wp_active
);
  localparam int IDX_W = $clog2(RAM_BYTES);
  localparam int CNT_W = $clog2(WIN_TICKS + 1);

  typedef enum logic [1:0] {K_IDLE, K_GOT0, K_GOT1, K_GOT3} kstate_t;

  kstate_t    kst;
  logic [CNT_W-1:0] win_cnt;
  logic [1:0] fld, want;
  logic       ctrl_wr, step_ok, unlock, rearm, in_ram;
  logic       unused_hi;

  assign fld       = wr_data[1:0];
  assign unused_hi = ^wr_data[DATA_W-1:2];
  assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    case (kst)
      K_IDLE:  want = 2'b00;
      K_GOT0:  want = 2'b01;
      K_GOT1:  want = 2'b11;
      default: want = 2'b10;
    endcase
  end

  assign step_ok = ctrl_wr && (fld == want);
  assign unlock  = step_ok && (kst == K_GOT3);
  assign rearm   = ctrl_wr && (fld == 2'b10) && !unlock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kst <= K_IDLE;
    end else if (ctrl_wr) begin
      if (unlock)           kst <= K_IDLE;
      else if (step_ok)     kst <= kstate_t'(kst + 2'd1);
      else if (fld == 2'b00) kst <= K_GOT0;
      else                  kst <= K_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        win_cnt <= '0;
    else if (unlock)                   win_cnt <= CNT_W'(WIN_TICKS);
    else if (rearm)                    win_cnt <= '0;
    else if (tick && win_cnt != '0)    win_cnt <= win_cnt - 1'b1;
  end

  assign wp_active = (win_cnt == '0);

  assign in_ram  = ({1'b0, wr_addr} >= (ADDR_W+1)'(RAM_BASE)) &&
                   ({1'b0, wr_addr} <  (ADDR_W+1)'(RAM_BASE + RAM_BYTES));
  assign wr_ok   = wr_en && (ctrl_wr || !wp_active);
  assign ram_wr  = wr_ok && in_ram && !ctrl_wr;
  assign ram_idx = IDX_W'(wr_addr - ADDR_W'(RAM_BASE));

  // R1
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_wr && wp_active) |-> !wr_ok);
  // R2
  ctrl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |-> wr_ok);
  // R3
  unlock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> !wp_active);
  // R7
  rearm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> wp_active);
  // R6
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && win_cnt == CNT_W'(1) && !unlock && !rearm) |=> wp_active);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_wr) |=> $stable(win_cnt));
  // R10
  ram_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_active |-> !ram_wr);
endmodule

// File: tb/sim_wp_knock_guard.sv
module sim_wp_knock_guard;
  localparam int AW = 8, DW = 16, CA = 'h10, RB = 'h40, RN = 64, WT = 3;

  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ok, ram_wr, wp_active;
  logic [5:0] ram_idx;

  int total = 0, bad = 0;
  int mst = 0, mcnt = 0;

  always #5 clk = ~clk;

  wp_knock_guard #(.ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(CA), .RAM_BASE(RB),
                   .RAM_BYTES(RN), .WIN_TICKS(WT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .wr_ok(wr_ok), .ram_wr(ram_wr),
    .ram_idx(ram_idx), .wp_active(wp_active));

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int want_of(int s);
    case (s) 0: return 0; 1: return 1; 2: return 3; default: return 2; endcase
  endfunction

  task automatic cyc(input logic we, input int a, input int d, input logic tk,
                     input string tag);
    logic e_ok, e_ram, e_wp;
    int f;
    bit is_ctrl, unl, rarm;
    wr_en = we; wr_addr = AW'(a); wr_data = DW'(d); tick = tk;
    #1;
    is_ctrl = we && (a == CA);
    e_wp  = (mcnt == 0);
    e_ok  = we && (is_ctrl || mcnt != 0);
    e_ram = e_ok && !is_ctrl && a >= RB && a < RB + RN;
    chk(wp_active === e_wp, tag, "wp_active", int'(wp_active), int'(e_wp));
    chk(wr_ok === e_ok, tag, "wr_ok", int'(wr_ok), int'(e_ok));
    chk(ram_wr === e_ram, tag, "ram_wr", int'(ram_wr), int'(e_ram));
    if (e_ram) chk(ram_idx === 6'(a - RB), tag, "ram_idx", int'(ram_idx), a - RB);
    @(posedge clk);
    f = d & 3;
    unl  = is_ctrl && mst == 3 && f == 2;
    rarm = is_ctrl && f == 2 && !unl;
    if (unl) mcnt = WT;
    else if (rarm) mcnt = 0;
    else if (tk && mcnt > 0) mcnt--;
    if (is_ctrl) begin
      if (f == want_of(mst)) mst = (mst == 3) ? 0 : mst + 1;
      else if (f == 0) mst = 1;
      else mst = 0;
    end
    @(negedge clk);
  endtask

  task automatic knock(input string tag, input logic last_tick);
    cyc(1, CA, 'h8000, 0, tag);
    cyc(1, CA, 'h8001, 0, tag);
    cyc(1, CA, 'h8003, 0, tag);
    cyc(1, CA, 'h8002, last_tick, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and locked writes
    cyc(0, 0, 0, 0, "R1");
    cyc(1, 'h20, 'h1234, 0, "R1");
    cyc(1, 'h90, 'h5555, 0, "R1");
    // R10 locked RAM write dropped
    cyc(1, 'h45, 'hAA, 0, "R10");
    // R6 ticks while locked
    cyc(0, 0, 0, 1, "R6"); cyc(1, 'h20, 0, 1, "R6");
    // R2 control write always passes
    cyc(1, CA, 'h8001, 0, "R2");
    // R4 broken sequence then restart with 00
    cyc(1, CA, 'h8000, 0, "R4"); cyc(1, CA, 'h8001, 0, "R4");
    cyc(1, CA, 'h8001, 0, "R4"); cyc(1, CA, 'h8003, 0, "R4");
    cyc(1, CA, 'h8002, 0, "R4"); cyc(1, 'h20, 0, 0, "R4");
    cyc(1, CA, 'h8000, 0, "R4"); cyc(1, CA, 'h8001, 0, "R4");
    cyc(1, CA, 'h8000, 0, "R4"); cyc(1, CA, 'h8001, 0, "R4");
    cyc(1, CA, 'h8003, 0, "R4"); cyc(1, CA, 'h8002, 0, "R4");
    cyc(1, 'h20, 'h77, 0, "R4");
    // R7 lone 10 closes it
    cyc(1, CA, 'h8002, 0, "R7"); cyc(1, 'h20, 0, 0, "R7");
    // R3 sequence with other writes interleaved
    cyc(1, CA, 'h8000, 0, "R3"); cyc(1, 'h20, 1, 0, "R3");
    cyc(1, CA, 'h8001, 0, "R3"); cyc(1, 'h41, 2, 0, "R3");
    cyc(1, CA, 'h8003, 0, "R3"); cyc(1, CA, 'h8002, 0, "R3");
    // R5 and R10 open window accesses and edges
    cyc(1, 'h20, 'h11, 0, "R5"); cyc(1, 'h90, 'h11, 0, "R5");
    cyc(1, 'h45, 'h22, 0, "R10"); cyc(1, 'h40, 'h22, 0, "R10");
    cyc(1, 'h7F, 'h33, 0, "R10"); cyc(1, 'h80, 'h33, 0, "R10");
    cyc(1, 'h3F, 'h33, 0, "R10");
    // R8 field 00/01/11 leave the window alone
    cyc(1, CA, 'h8000, 0, "R8"); cyc(1, CA, 'h8001, 0, "R8");
    cyc(1, CA, 'h8003, 0, "R8"); cyc(1, CA, 'h8001, 0, "R8");
    cyc(1, 'h50, 0, 0, "R8");
    // R6 expiry over WT ticks
    cyc(0, 0, 0, 1, "R6"); idle(2, "R6"); cyc(1, 'h20, 0, 1, "R6");
    idle(1, "R6"); cyc(0, 0, 0, 1, "R6"); cyc(1, 'h20, 0, 0, "R6");
    idle(2, "R6");
    // R7 rearm after fresh unlock
    knock("R7", 0); cyc(1, CA, 'h8002, 0, "R7"); cyc(1, 'h44, 0, 0, "R7");
    // R9 restart window, R11 unlock beats tick
    knock("R9", 0); cyc(0, 0, 0, 1, "R9"); cyc(0, 0, 0, 1, "R9");
    knock("R11", 1);
    cyc(0, 0, 0, 1, "R9"); cyc(0, 0, 0, 1, "R9"); cyc(1, 'h60, 0, 0, "R9");
    cyc(0, 0, 0, 1, "R9"); cyc(1, 'h60, 0, 0, "R9");
    knock("R11", 1); idle(3, "R11");
    for (int i = 0; i < WT; i++) cyc(0, 0, 0, 1, "R6");
    cyc(1, 'h60, 0, 0, "R6");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule